// File: doc/BRIEF.md
# Weighted Table Output Scheduler

This block decides which of several per-class output queues may send its head packet next on a link that moves one flit per cycle. A programmable schedule table drives the choice. Each row names a queue and carries a weight, and the weight times a fixed scale factor is that row's turn length in flits. Packets vary in length, so the head packet of the queue named by the current row is granted only if it fits in the turn credit still left. A row that cannot send gives up its turn and the search moves to the next row in table order. Several rows may name the same queue, which shortens the gap between that queue's turns.

A runtime mode selects what happens to leftover credit. In basic mode a skipped row loses whatever it had left. In carry mode each row has its own carry register. Credit left over because a head packet was too long is stored there and added to the row's credit on its next visit. The carry is cleared when the row is passed over because its queue is inactive.

The table is written through a simple write port while the scheduler is disabled. A grant starts the granted packet's transmission, one flit per cycle. The next search runs in the cycle that carries the last flit, so packets can follow back to back. The search covers every active row exactly once, in a single cycle.

Top module: `wtab_sched`

## Requirements
- R1: After reset, `gnt_valid`, `arb_none` and `tx_flit` are 0, and the first search starts at row 0 with row 0's full turn credit (weight × KSCALE flits).
- R2: A row is eligible only if its queue has `q_nonempty` = 1, has `q_permit` = 1, and has a head length (field `q_head_len[q*LW +: LW]`) no larger than the row's remaining credit.
- R3: A grant subtracts the packet length from the credit. If credit remains, the same row stays current for the next search. When the credit reaches exactly 0, the next row becomes current with a fresh turn.
- R4: In basic mode (`deficit_mode` = 0), a row that is not eligible is skipped and its leftover credit is lost. The next row starts with its own full turn.
- R5: One search visits rows in table order, starting at the current row and wrapping from row `entry_count`-1 to row 0. Rows at or above `entry_count` are never used, and several rows may name the same queue.
- R6: If some queue is non-empty but no active row is eligible, `arb_none` pulses for one cycle, no grant is issued, and the current row and its credit are kept.
- R7: While every queue is empty, no search takes place: no grant, no `arb_none`, and the current row and its credit are kept.
- R8: In carry mode (`deficit_mode` = 1), a row skipped only because its head packet is too long stores its leftover credit. That credit is added to the row's turn on its next visit and consumed when the row grants.
- R9: In carry mode, a row passed over because its queue is inactive (empty or not permitted) has its stored carry cleared to 0.
- R10: A grant drives `gnt_valid` for one cycle and `tx_flit` for exactly as many cycles as the packet length. No new grant is issued before the cycle after the last flit, and when a packet is ready the next grant follows at once.
- R11: Table writes take effect only while `enable` = 0. A write attempted while enabled changes nothing.
- R12: While `enable` = 0, no search takes place and neither `gnt_valid` nor `arb_none` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Scheduler run enable; table writes allowed only when 0 |
| deficit_mode | input | 1 | 0 = basic (leftover lost), 1 = carry leftover per row |
| entry_count | input | EIW+1 (6) | Number of active table rows, 1..NE |
| cfg_we | input | 1 | Table write strobe |
| cfg_entry | input | EIW (5) | Table row to write |
| cfg_queue | input | QIW (4) | Queue named by the row |
| cfg_weight | input | WW (16) | Row weight |
| q_nonempty | input | NQ (16) | Per-queue non-empty flags |
| q_permit | input | NQ (16) | Per-queue flow-control permits |
| q_head_len | input | NQ*LW (128) | Per-queue head packet length in flits, queue q at bits q*LW +: LW |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_queue | output | QIW (4) | Granted queue index, valid with `gnt_valid` |
| arb_none | output | 1 | One-cycle pulse: a search found no eligible row |
| tx_flit | output | 1 | A flit of the granted packet occupies the link this cycle |
| tx_queue | output | QIW (4) | Queue whose packet is on the link |

## Verification
The bench targets a head packet that is too long for the credit left. A scheduler that ignored the length would send it anyway, and one that kept basic-mode leftovers would reorder the grants relative to the hand-worked sequences. Carry mode is checked twice: once where the saved credit lets a row send two packets in a row, and once where the queue goes inactive for one visit. In the second case a scheduler that failed to clear the carry would grant the long packet one turn early. Other cases cover wrap at the active row count with a queue named twice, rows beyond the count that must never be used, and all-empty idle periods that must leave the current row's partial credit intact. The bench also checks flit counts and back-to-back grant spacing, and table writes made while enabled that must not redirect a row.

// File: rtl/wtab_pkg.sv
package wtab_pkg;

  // Turn length in flits for a row weight.
  function automatic int unsigned quantum_of(input int unsigned weight,
                                             input int unsigned scale);
    return weight * scale;
  endfunction

  // Row following 'entry' when 'count' rows are active.
  function automatic int unsigned wrap_next(input int unsigned entry,
                                            input int unsigned count);
    if (entry + 1 >= count) return 0;
    return entry + 1;
  endfunction

  // Row reached 'offset' steps after 'base' in a ring of 'count' rows.
  function automatic int unsigned ring_index(input int unsigned base,
                                             input int unsigned offset,
                                             input int unsigned count);
    int unsigned s;
    s = base + offset;
    if (s >= count) s = s - count;
    return s;
  endfunction

endpackage

// File: rtl/wtab_table.sv
module wtab_table #(
  parameter int NE  = 32,
  parameter int WW  = 16,
  parameter int QIW = 4,
  parameter int EIW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cfg_we,
  input  logic [EIW-1:0]      cfg_entry,
  input  logic [QIW-1:0]      cfg_queue,
  input  logic [WW-1:0]       cfg_weight,
  output logic [NE*QIW-1:0]   tab_queue,
  output logic [NE*WW-1:0]    tab_weight
);

  logic wr_ok;
  assign wr_ok = cfg_we && !enable;

  for (genvar e = 0; e < NE; e++) begin : g_row
    logic [QIW-1:0] q_r;
    logic [WW-1:0]  w_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_r <= '0;
        w_r <= '0;
      end else if (wr_ok && cfg_entry == EIW'(e)) begin
        q_r <= cfg_queue;
        w_r <= cfg_weight;
      end
    end
    assign tab_queue[e*QIW +: QIW] = q_r;
    assign tab_weight[e*WW +: WW]  = w_r;
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(tab_queue) && $stable(tab_weight)));  // R11

endmodule

// File: rtl/wtab_scan.sv
module wtab_scan #(
  parameter int NQ     = 16,
  parameter int NE     = 32,
  parameter int WW     = 16,
  parameter int KSCALE = 2,
  parameter int LW     = 8,
  parameter int QIW    = 4,
  parameter int EIW    = 5,
  parameter int CW     = 19
) (
  input  logic [EIW-1:0]    cur,
  input  logic              fresh,
  input  logic [CW-1:0]     rem,
  input  logic [EIW:0]      cnt,
  input  logic              mode,
  input  logic [NE*QIW-1:0] tab_queue,
  input  logic [NE*WW-1:0]  tab_weight,
  input  logic [NE*CW-1:0]  def_flat,
  input  logic [NQ-1:0]     q_ready,
  input  logic [NQ*LW-1:0]  q_len,
  output logic              hit,
  output logic [EIW-1:0]    hit_entry,
  output logic [QIW-1:0]    hit_queue,
  output logic [LW-1:0]     hit_len,
  output logic [CW-1:0]     hit_credit,
  output logic [NE-1:0]     skip_mask,
  output logic [NE-1:0]     keep_mask,
  output logic [NE*CW-1:0]  credit_flat
);

  localparam int EW = EIW + 1;

  logic [NE-1:0]  elig;
  logic [QIW-1:0] qid_arr [NE];
  logic [LW-1:0]  len_arr [NE];
  logic [CW-1:0]  crd_arr [NE];

  // Per-row view: credit on this visit and whether the row can send.
  for (genvar e = 0; e < NE; e++) begin : g_row
    logic [QIW-1:0] qid;
    logic [CW-1:0]  quant;
    logic [CW-1:0]  credit;
    logic [LW-1:0]  len;
    assign qid    = tab_queue[e*QIW +: QIW];
    assign quant  = CW'(wtab_pkg::quantum_of(32'(tab_weight[e*WW +: WW]), KSCALE));
    assign credit = (cur == EIW'(e) && !fresh) ? rem
                  : quant + (mode ? def_flat[e*CW +: CW] : '0);
    assign len    = q_len[qid*LW +: LW];
    assign elig[e]      = q_ready[qid] && (CW'(len) <= credit) && (EW'(e) < cnt);
    assign keep_mask[e] = mode && q_ready[qid];
    assign credit_flat[e*CW +: CW] = credit;
    assign qid_arr[e] = qid;
    assign len_arr[e] = len;
    assign crd_arr[e] = credit;
  end

  // Rotating priority search starting at the current row.
  logic [EIW-1:0] idx;
  always_comb begin
    hit       = 1'b0;
    hit_entry = '0;
    skip_mask = '0;
    idx       = '0;
    for (int i = 0; i < NE; i++) begin
      if (EW'(i) < cnt && !hit) begin
        idx = EIW'(wtab_pkg::ring_index(32'(cur), 32'(i), 32'(cnt)));
        if (elig[idx]) begin
          hit       = 1'b1;
          hit_entry = idx;
        end else begin
          skip_mask[idx] = 1'b1;
        end
      end
    end
  end

  assign hit_queue  = qid_arr[hit_entry];
  assign hit_len    = len_arr[hit_entry];
  assign hit_credit = crd_arr[hit_entry];

endmodule

// File: rtl/wtab_carry.sv
module wtab_carry #(
  parameter int NE  = 32,
  parameter int EIW = 5,
  parameter int CW  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [EIW-1:0]    hit_entry,
  input  logic [NE-1:0]     skip_mask,
  input  logic [NE-1:0]     keep_mask,
  input  logic [NE*CW-1:0]  credit_flat,
  output logic [NE*CW-1:0]  def_flat
);

  logic [CW-1:0] def_arr [NE];

  for (genvar e = 0; e < NE; e++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        def_arr[e] <= '0;
      end else if (upd) begin
        if (hit_entry == EIW'(e))
          def_arr[e] <= '0;
        else if (skip_mask[e])
          def_arr[e] <= keep_mask[e] ? credit_flat[e*CW +: CW] : '0;
      end
    end
    assign def_flat[e*CW +: CW] = def_arr[e];
  end

  AST_CARRY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (def_arr[$past(hit_entry)] == '0));  // R8

endmodule

// File: rtl/wtab_sched.sv
module wtab_sched #(
  parameter int NQ     = 16,
  parameter int NE     = 32,
  parameter int WW     = 16,
  parameter int KSCALE = 2,
  parameter int LW     = 8,
  localparam int QIW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int EIW   = (NE > 1) ? $clog2(NE) : 1,
  localparam int CW    = WW + $clog2(KSCALE + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              deficit_mode,
  input  logic [EIW:0]      entry_count,
  input  logic              cfg_we,
  input  logic [EIW-1:0]    cfg_entry,
  input  logic [QIW-1:0]    cfg_queue,
  input  logic [WW-1:0]     cfg_weight,
  input  logic [NQ-1:0]     q_nonempty,
  input  logic [NQ-1:0]     q_permit,
  input  logic [NQ*LW-1:0]  q_head_len,
  output logic              gnt_valid,
  output logic [QIW-1:0]    gnt_queue,
  output logic              arb_none,
  output logic              tx_flit,
  output logic [QIW-1:0]    tx_queue
);

  logic [NE*QIW-1:0] tab_queue;
  logic [NE*WW-1:0]  tab_weight;
  logic [NE*CW-1:0]  def_flat;
  logic [NE*CW-1:0]  credit_flat;
  logic [NE-1:0]     skip_mask, keep_mask;
  logic              hit;
  logic [EIW-1:0]    hit_entry;
  logic [QIW-1:0]    hit_queue;
  logic [LW-1:0]     hit_len;
  logic [CW-1:0]     hit_credit;

  logic [EIW-1:0]    cur_q;
  logic              fresh_q;
  logic [CW-1:0]     rem_q;
  logic [LW-1:0]     send_left;
  logic [QIW-1:0]    txq_q;
  logic              gnt_q, none_q;

  // Named internal events.
  logic              any_nonempty, arb_slot, arb_try, arb_fire, arb_miss;
  logic [CW-1:0]     credit_left;
  logic              depleted;
  logic [NQ-1:0]     q_ready;

  assign q_ready      = q_nonempty & q_permit;
  assign any_nonempty = |q_nonempty;
  assign arb_slot     = enable && (send_left <= LW'(1));
  assign arb_try      = arb_slot && any_nonempty;
  assign arb_fire     = arb_try && hit;
  assign arb_miss     = arb_try && !hit;
  assign credit_left  = hit_credit - CW'(hit_len);
  assign depleted     = (credit_left == '0);

  wtab_table #(.NE(NE), .WW(WW), .QIW(QIW), .EIW(EIW)) u_table (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_entry(cfg_entry), .cfg_queue(cfg_queue), .cfg_weight(cfg_weight),
    .tab_queue(tab_queue), .tab_weight(tab_weight)
  );

  wtab_scan #(.NQ(NQ), .NE(NE), .WW(WW), .KSCALE(KSCALE), .LW(LW),
              .QIW(QIW), .EIW(EIW), .CW(CW)) u_scan (
    .cur(cur_q), .fresh(fresh_q), .rem(rem_q), .cnt(entry_count),
    .mode(deficit_mode), .tab_queue(tab_queue), .tab_weight(tab_weight),
    .def_flat(def_flat), .q_ready(q_ready), .q_len(q_head_len),
    .hit(hit), .hit_entry(hit_entry), .hit_queue(hit_queue),
    .hit_len(hit_len), .hit_credit(hit_credit), .skip_mask(skip_mask),
    .keep_mask(keep_mask), .credit_flat(credit_flat)
  );

  wtab_carry #(.NE(NE), .EIW(EIW), .CW(CW)) u_carry (
    .clk(clk), .rst_n(rst_n), .upd(arb_fire), .hit_entry(hit_entry),
    .skip_mask(skip_mask), .keep_mask(keep_mask),
    .credit_flat(credit_flat), .def_flat(def_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q     <= '0;
      fresh_q   <= 1'b1;
      rem_q     <= '0;
      send_left <= '0;
      txq_q     <= '0;
      gnt_q     <= 1'b0;
      none_q    <= 1'b0;
    end else begin
      gnt_q  <= arb_fire;
      none_q <= arb_miss;
      if (arb_fire) begin
        send_left <= hit_len;
        txq_q     <= hit_queue;
        if (depleted) begin
          cur_q   <= EIW'(wtab_pkg::wrap_next(32'(hit_entry), 32'(entry_count)));
          fresh_q <= 1'b1;
          rem_q   <= '0;
        end else begin
          cur_q   <= hit_entry;
          fresh_q <= 1'b0;
          rem_q   <= credit_left;
        end
      end else if (send_left != '0) begin
        send_left <= send_left - LW'(1);
      end
    end
  end

  assign gnt_valid = gnt_q;
  assign gnt_queue = txq_q;
  assign arb_none  = none_q;
  assign tx_flit   = (send_left != '0);
  assign tx_queue  = txq_q;

  AST_FIRE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_fire |-> (q_nonempty[hit_queue] && q_permit[hit_queue] && (CW'(hit_len) <= hit_credit)));  // R2
  AST_CREDIT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_q |-> (rem_q != '0));  // R3
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    arb_miss |=> ($stable(cur_q) && $stable(rem_q) && $stable(fresh_q) && arb_none));  // R6
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !any_nonempty) |=> ($stable(cur_q) && $stable(rem_q) && !gnt_valid && !arb_none));  // R7
  AST_HOLD_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (send_left > LW'(1)) |=> (tx_flit && !gnt_valid));  // R10
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gnt_valid && !arb_none));  // R12

endmodule

// File: tb/wtab_sched_test.sv
`timescale 1ns/1ps
module wtab_sched_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         deficit_mode = 1'b0;
  logic [5:0]   entry_count = 6'd2;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_entry = '0;
  logic [3:0]   cfg_queue = '0;
  logic [15:0]  cfg_weight = '0;
  logic [15:0]  q_nonempty = '0;
  logic [15:0]  q_permit = '1;
  logic [127:0] q_head_len = '0;
  logic         gnt_valid, arb_none, tx_flit;
  logic [3:0]   gnt_queue, tx_queue;

  always #2 clk = ~clk;

  wtab_sched uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .deficit_mode(deficit_mode),
    .entry_count(entry_count), .cfg_we(cfg_we), .cfg_entry(cfg_entry),
    .cfg_queue(cfg_queue), .cfg_weight(cfg_weight), .q_nonempty(q_nonempty),
    .q_permit(q_permit), .q_head_len(q_head_len), .gnt_valid(gnt_valid),
    .gnt_queue(gnt_queue), .arb_none(arb_none), .tx_flit(tx_flit),
    .tx_queue(tx_queue)
  );

  // Queue model
  int qd [16][8];
  int qh [16];
  int qt [16];
  bit [15:0] permit;
  int glog [32];
  int gcyc [32];
  int glen [32];
  int gn, cyc, flit_cnt, none_cnt, mq;
  int nchk, nfail;

  function automatic void refresh();
    for (int q = 0; q < 16; q++) begin
      q_nonempty[q] = (qt[q] > qh[q]);
      q_head_len[q*8 +: 8] = (qt[q] > qh[q]) ? 8'(qd[q][qh[q] % 8]) : 8'd0;
    end
    q_permit = permit;
  endfunction

  task automatic push(input int q, input int len);
    qd[q][qt[q] % 8] = len;
    qt[q]++;
    refresh();
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (tx_flit) flit_cnt++;
      if (arb_none) none_cnt++;
      if (gnt_valid && gn < 32) begin
        mq = int'(gnt_queue);
        glog[gn] = mq;
        gcyc[gn] = cyc;
        glen[gn] = (qt[mq] > qh[mq]) ? qd[mq][qh[mq] % 8] : -1;
        if (qt[mq] > qh[mq]) qh[mq]++;
        gn++;
        refresh();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input bit mode, input int count);
    @(negedge clk); #1;
    rst_n = 1'b0;
    enable = 1'b0;
    cfg_we = 1'b0;
    deficit_mode = mode;
    entry_count = 6'(count);
    for (int q = 0; q < 16; q++) begin qh[q] = 0; qt[q] = 0; end
    permit = '1;
    gn = 0; flit_cnt = 0; none_cnt = 0;
    refresh();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic cfg_write(input int e, input int q, input int w);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_entry = 5'(e); cfg_queue = 4'(q); cfg_weight = 16'(w);
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_en(input bit b);
    @(negedge clk); #1 enable = b;
  endtask

  task automatic wait_grants(input int n);
    int k = 0;
    while (gn < n && k < 500) begin @(negedge clk); k++; end
    #1;
  endtask

  task automatic expect_seq(input string tag, input int exp [5]);
    chk(gn >= 5, tag, gn, 5);
    for (int k = 0; k < 5; k++) chk(glog[k] == exp[k], tag, glog[k], exp[k]);
  endtask

  // Two rows, q0 = [1,2,1], q1 = [2,1]
  task automatic load_pair_case(input bit mode);
    start(mode, 2);
    cfg_write(0, 0, 1);
    cfg_write(1, 1, 1);
    push(0, 1); push(0, 2); push(0, 1);
    push(1, 2); push(1, 1);
    set_en(1'b1);
    wait_grants(5);
  endtask

  task automatic t_reset();
    start(1'b0, 2);
    chk(gnt_valid == 1'b0, "R1 reset gnt_valid", int'(gnt_valid), 0);
    chk(arb_none == 1'b0, "R1 reset arb_none", int'(arb_none), 0);
    chk(tx_flit == 1'b0, "R1 reset tx_flit", int'(tx_flit), 0);
  endtask

  task automatic t_basic();
    load_pair_case(1'b0);
    chk(glog[0] == 0, "R1 first grant from row 0", glog[0], 0);
    expect_seq("R3 R4 basic sequence", '{0, 1, 0, 1, 0});
    for (int k = 1; k < 5; k++)
      chk(gcyc[k] - gcyc[k-1] == glen[k-1], "R10 grant spacing", gcyc[k] - gcyc[k-1], glen[k-1]);
    repeat (10) @(negedge clk);
    chk(flit_cnt == 7, "R10 flit count", flit_cnt, 7);
  endtask

  task automatic t_carry();
    load_pair_case(1'b1);
    expect_seq("R8 carry sequence", '{0, 1, 0, 0, 1});
  endtask

  task automatic t_wrap();
    start(1'b0, 3);
    cfg_write(0, 2, 1);
    cfg_write(1, 3, 1);
    cfg_write(2, 2, 1);
    cfg_write(3, 5, 9);
    push(2, 2); push(2, 2); push(2, 2);
    push(3, 2); push(3, 2);
    push(5, 1); push(5, 1);
    set_en(1'b1);
    wait_grants(5);
    expect_seq("R5 wrap and shared queue", '{2, 3, 2, 2, 3});
    repeat (20) @(negedge clk);
    chk(gn == 5, "R5 row beyond count unused", gn, 5);
    chk(none_cnt > 0, "R6 no eligible row pulse", none_cnt, 1);
  endtask

  task automatic t_permit();
    start(1'b0, 2);
    cfg_write(0, 0, 2);
    cfg_write(1, 1, 2);
    push(0, 1); push(1, 1);
    permit[0] = 1'b0; refresh();
    set_en(1'b1);
    wait_grants(1);
    chk(glog[0] == 1, "R2 blocked queue skipped", glog[0], 1);
    repeat (10) @(negedge clk);
    chk(gn == 1, "R6 no grant while blocked", gn, 1);
    chk(none_cnt > 0, "R6 arb_none while blocked", none_cnt, 1);
    #1 permit[0] = 1'b1; refresh();
    wait_grants(2);
    chk(glog[1] == 0, "R2 permit restored", glog[1], 0);
  endtask

  task automatic t_idle();
    start(1'b0, 2);
    cfg_write(0, 0, 1);
    cfg_write(1, 1, 1);
    push(0, 1);
    set_en(1'b1);
    wait_grants(1);
    repeat (20) @(negedge clk);
    chk(gn == 1, "R7 no grant while empty", gn, 1);
    chk(none_cnt == 0, "R7 no arb_none while empty", none_cnt, 0);
    #1 push(0, 2); push(1, 1);
    wait_grants(3);
    chk(glog[1] == 1, "R7 partial credit kept", glog[1], 1);
    chk(glog[2] == 0, "R7 follow-up grant", glog[2], 0);
  endtask

  task automatic t_lock();
    start(1'b0, 2);
    cfg_write(0, 0, 1);
    cfg_write(1, 1, 1);
    push(0, 1);
    repeat (10) @(negedge clk);
    chk(gn == 0, "R12 no grant while disabled", gn, 0);
    chk(none_cnt == 0, "R12 no arb_none while disabled", none_cnt, 0);
    set_en(1'b1);
    wait_grants(1);
    chk(glog[0] == 0, "R11 first grant", glog[0], 0);
    cfg_write(0, 4, 5);
    #1 push(0, 1); push(4, 1);
    wait_grants(2);
    repeat (20) @(negedge clk);
    chk(gn == 2, "R11 write while enabled ignored", gn, 2);
    chk(glog[1] == 0, "R11 row keeps its queue", glog[1], 0);
  endtask

  task automatic t_carry_clear();
    start(1'b1, 2);
    cfg_write(0, 0, 1);
    cfg_write(1, 1, 2);
    push(0, 1); push(0, 3);
    push(1, 4); push(1, 4); push(1, 4);
    set_en(1'b1);
    wait_grants(2);
    permit[0] = 1'b0; refresh();
    wait_grants(3);
    permit[0] = 1'b1; refresh();
    wait_grants(5);
    expect_seq("R9 carry cleared on inactive skip", '{0, 1, 1, 1, 0});
  endtask

  initial begin
    nchk = 0; nfail = 0; gn = 0; cyc = 0;
    permit = '1;
    t_reset();
    t_basic();
    t_carry();
    t_wrap();
    t_permit();
    t_idle();
    t_lock();
    t_carry_clear();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule